// File: doc/BRIEF.md
# Chained dual CRC-8 packet checker

This block checks a received packet that sits in a byte-addressed buffer. It reads the packet through a simple synchronous read port. Byte 0 is a header, and its low five bits give the packet length N. The packet ends in two check bytes. Two CRC-8 registers run side by side. Both start from 0xFF and both shift MSB-first. The first uses polynomial 0x31 and covers every byte before the first check byte. The second uses polynomial 0x8C and runs one byte further, so its span also takes in the first check byte. The packet passes only when both computed values equal the stored check bytes.

A pulse on `start` while the block is idle begins a check. `busy` stays high while the bytes are fetched. A one-cycle `done` pulse then marks the verdict on `crc_ok`, and that verdict holds until the next accepted start. A header that declares fewer than three bytes cannot carry two check bytes, so the block rejects it right after the header byte. The parameter `STEP` sets how many bits each CRC register takes in per clock. At 8 the block takes one byte per cycle. At 1 it takes one bit per cycle and spends eight cycles on each byte.

Top module: `dcrc_checker`

## Requirements
- R1: The first check value starts at 0xFF. It takes each byte MSB-first with polynomial 0x31, so that for each byte the byte is XORed into the register and then the register shifts left 8 times, XORing 0x31 after any shift that pushes out a 1. It covers bytes 0 to N-3, and the check fails unless the result equals byte N-2.
- R2: The second check value uses the same procedure with polynomial 0x8C over bytes 0 to N-2, which includes byte N-2 itself. The check fails unless the result equals byte N-1. A value computed only over bytes 0 to N-3 must be rejected.
- R3: `crc_ok` is 1 after a check only when both stored check bytes match. Any changed payload byte or check byte gives 0.
- R4: N is taken from bits [4:0] of byte 0, and bits [7:5] of byte 0 have no effect on the length. They take part in both CRCs only as ordinary data.
- R5: When N is less than 3 (that is, 0, 1 or 2), the block reads only byte 0, pulses `done` two cycles after the start edge and gives `crc_ok` = 0.
- R6: `done` is high for exactly one cycle per check. `crc_ok` is low while `busy` is high. `crc_ok` is valid from the `done` cycle and stays unchanged until the next accepted start.
- R7: `busy` rises in the cycle after an accepted start and is low in the `done` cycle. A `start` while `busy` is high is ignored: it produces no extra `done`, no extra read and no change to the result or its timing.
- R8: A read is a cycle with `rd_en` high. The byte at `rd_addr` must appear on `rd_data` in the next cycle. A check reads addresses 0 to N-1, each exactly once and in order, and never reads beyond N-1.
- R9: Counting the edge that samples `start` as edge 0, `done` goes high after edge 1 + (8/STEP)*(N-1). That is edge N for STEP = 8 and edge 8N-7 for STEP = 1.
- R10: After reset, `busy`, `done`, `crc_ok` and `rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (taken only while idle) |
| rd_en | output | 1 | Read request to the packet buffer |
| rd_addr | output | LEN_BITS | Byte address of the read |
| rd_data | input | 8 | Byte returned one cycle after the read |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| crc_ok | output | 1 | Verdict: both check bytes match |

## Verification
The hardest case to reach from the ports is a stored second check byte that was computed over the wrong span. A value that leaves out the first check byte looks plausible, but the block must still reject it. The bench builds such a packet on purpose. It also builds packets where only the first check byte, only the second, or only one payload byte is wrong, so each comparison is exercised on its own. A byte-wide instance and a bit-serial instance read the same buffer in every test. This checks the exact `done` cycle for both beat counts, including the shortest legal packet, the longest legal packet and the three headers declaring fewer than three bytes. A second `start` is pulsed in the middle of a bit-serial run to show that it changes neither the read count nor the timing.

// File: rtl/dcrc_pkg.sv
package dcrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } dcrc_state_e;

    // One MSB-first CRC-8 step on a single incoming data bit.
    function automatic logic [7:0] crc8_bit_step(input logic [7:0] c,
                                                 input logic       d,
                                                 input logic [7:0] poly);
        logic fbk;
        fbk = c[7] ^ d;
        return {c[6:0], 1'b0} ^ (fbk ? poly : 8'h00);
    endfunction

endpackage

// File: rtl/dcrc_engine.sv
module dcrc_engine
    import dcrc_pkg::*;
#(
    parameter int         STEP = 8,
    parameter logic [7:0] POLY = 8'h31,
    parameter logic [7:0] SEED = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            en,
    input  logic [STEP-1:0] din,
    output logic [7:0]      crc_q
);

    typedef struct packed {
        logic [7:0] crc;
    } eng_s;

    eng_s r_q, r_d;
    logic [7:0] stepped;

    always_comb begin
        stepped = r_q.crc;
        for (int i = STEP - 1; i >= 0; i--) begin
            stepped = crc8_bit_step(stepped, din[i], POLY);
        end
        r_d = r_q;
        if (init) begin
            r_d.crc = SEED;
        end else if (en) begin
            r_d.crc = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{crc: SEED};
        end else begin
            r_q <= r_d;
        end
    end

    assign crc_q = r_q.crc;

    // R1
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !en) |=> $stable(crc_q));

endmodule

// File: rtl/dcrc_ctrl.sv
module dcrc_ctrl
    import dcrc_pkg::*;
#(
    parameter int STEP     = 8,
    parameter int LEN_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          rd_data,
    input  logic [7:0]          crc_a,
    input  logic [7:0]          crc_b,
    output logic                rd_en,
    output logic [LEN_BITS-1:0] rd_addr,
    output logic                eng_init,
    output logic                en_a,
    output logic                en_b,
    output logic [STEP-1:0]     eng_din,
    output logic                busy,
    output logic                done,
    output logic                crc_ok
);

    localparam int BEATS = 8 / STEP;
    localparam int BCW   = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int LW    = LEN_BITS;

    typedef struct packed {
        dcrc_state_e st;
        logic [LW-1:0] idx;
        logic [LW-1:0] len;
        logic [7:0]    sh;
        logic [BCW-1:0] beat;
        logic          fa;
        logic          fb;
        logic          match_a;
        logic          done;
        logic          ok;
    } ctl_s;

    ctl_s r_q, r_d;

    logic [LW-1:0] len_now;
    logic [LW:0]   k1, k2, k3, len_x;
    logic          feed_a, feed_b;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        rd_en    = 1'b0;
        rd_addr  = r_q.idx + 1'b1;
        eng_init = 1'b0;
        en_a     = 1'b0;
        en_b     = 1'b0;
        eng_din  = rd_data[7 -: STEP];
        len_now  = (r_q.idx == '0) ? rd_data[LW-1:0] : r_q.len;
        len_x    = {1'b0, len_now};
        k1       = {1'b0, r_q.idx} + (LW+1)'(1);
        k2       = {1'b0, r_q.idx} + (LW+1)'(2);
        k3       = {1'b0, r_q.idx} + (LW+1)'(3);
        feed_a   = (k3 <= len_x);
        feed_b   = (k2 <= len_x);

        unique case (r_q.st)
            ST_IDLE: begin
                rd_addr = '0;
                if (start) begin
                    rd_en       = 1'b1;
                    eng_init    = 1'b1;
                    r_d.st      = ST_WAIT;
                    r_d.idx     = '0;
                    r_d.ok      = 1'b0;
                    r_d.match_a = 1'b0;
                end
            end

            ST_WAIT: begin
                r_d.len = len_now;
                if ((r_q.idx == '0) && (len_now < LW'(3))) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.ok   = 1'b0;
                end else if (k1 == len_x) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.ok   = r_q.match_a && (rd_data == crc_b);
                end else begin
                    if (k2 == len_x) begin
                        r_d.match_a = (rd_data == crc_a);
                    end
                    en_a   = feed_a;
                    en_b   = feed_b;
                    r_d.fa = feed_a;
                    r_d.fb = feed_b;
                    r_d.sh = 8'(rd_data << STEP);
                    if (BEATS == 1) begin
                        rd_en   = 1'b1;
                        r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.st   = ST_SHIFT;
                        r_d.beat = BCW'(1);
                    end
                end
            end

            ST_SHIFT: begin
                eng_din = r_q.sh[7 -: STEP];
                en_a    = r_q.fa;
                en_b    = r_q.fb;
                r_d.sh  = 8'(r_q.sh << STEP);
                if (r_q.beat == BCW'(BEATS - 1)) begin
                    rd_en   = 1'b1;
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_WAIT;
                end else begin
                    r_d.beat = r_q.beat + 1'b1;
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = r_q.done;
    assign crc_ok = r_q.ok;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |-> !rd_en);

    // R6
    ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc_ok));

    // R3
    ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ok) |-> done);

endmodule

// File: rtl/dcrc_checker.sv
module dcrc_checker
    import dcrc_pkg::*;
#(
    parameter int         STEP     = 8,
    parameter int         LEN_BITS = 5,
    parameter logic [7:0] POLY_A   = 8'h31,
    parameter logic [7:0] POLY_B   = 8'h8C,
    parameter logic [7:0] SEED     = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                rd_en,
    output logic [LEN_BITS-1:0] rd_addr,
    input  logic [7:0]          rd_data,
    output logic                busy,
    output logic                done,
    output logic                crc_ok
);

    localparam int NUM_CRC = 2;

    logic              eng_init;
    logic [STEP-1:0]   eng_din;
    logic [NUM_CRC-1:0] eng_en;
    logic [7:0]        crc_v [NUM_CRC];

    dcrc_ctrl #(
        .STEP     (STEP),
        .LEN_BITS (LEN_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_data  (rd_data),
        .crc_a    (crc_v[0]),
        .crc_b    (crc_v[1]),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .eng_init (eng_init),
        .en_a     (eng_en[0]),
        .en_b     (eng_en[1]),
        .eng_din  (eng_din),
        .busy     (busy),
        .done     (done),
        .crc_ok   (crc_ok)
    );

    for (genvar g = 0; g < NUM_CRC; g++) begin : g_eng
        dcrc_engine #(
            .STEP (STEP),
            .POLY ((g == 0) ? POLY_A : POLY_B),
            .SEED (SEED)
        ) u_eng (
            .clk   (clk),
            .rst_n (rst_n),
            .init  (eng_init),
            .en    (eng_en[g]),
            .din   (eng_din),
            .crc_q (crc_v[g])
        );
    end

endmodule

// File: tb/tb_dcrc_checker.sv
`timescale 1ns/1ps
module tb_dcrc_checker;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #5 clk = ~clk;

    logic [7:0] pkt [32];

    logic       rd_en0, rd_en1, busy0, busy1, done0, done1, ok0, ok1;
    logic [4:0] addr0, addr1;
    logic [7:0] data0, data1;

    dcrc_checker #(.STEP(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en0), .rd_addr(addr0),
        .rd_data(data0), .busy(busy0), .done(done0), .crc_ok(ok0));

    dcrc_checker #(.STEP(1)) dut_bit (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en1), .rd_addr(addr1),
        .rd_data(data1), .busy(busy1), .done(done1), .crc_ok(ok1));

    int rdc0 = 0, rdc1 = 0, dnc0 = 0, dnc1 = 0;
    always_ff @(posedge clk) begin
        if (rd_en0) begin data0 <= pkt[addr0]; rdc0 <= rdc0 + 1; end
        if (rd_en1) begin data1 <= pkt[addr1]; rdc1 <= rdc1 + 1; end
        if (done0) dnc0 <= dnc0 + 1;
        if (done1) dnc1 <= dnc1 + 1;
    end

    int tests = 0, fails = 0, cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit cond, input string req, input string msg,
                       input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, msg, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    function automatic logic [7:0] ref_crc(input int last, input logic [7:0] poly);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i <= last; i++) begin
            c ^= pkt[i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic build(input logic [2:0] top, input int n);
        pkt[0] = {top, 5'(n)};
        for (int i = 1; i < 32; i++) pkt[i] = rnd();
        if (n >= 3) begin
            pkt[n-2] = ref_crc(n - 3, 8'h31);
            pkt[n-1] = ref_crc(n - 2, 8'h8C);
        end
    endtask

    // Runs one check on both instances; n is the header length.
    task automatic run_check(input string req, input string name, input int n,
                             input bit exp_ok, input bit dbl);
        int t0 = -1, t1 = -1, e0, e1, lim, r0, r1, d0, d1, nrd;
        e0  = (n < 3) ? 2 : 2 + (n - 1);
        e1  = (n < 3) ? 2 : 2 + 8 * (n - 1);
        nrd = (n < 3) ? 1 : n;
        lim = e1 + 3;
        @(negedge clk);
        r0 = rdc0; r1 = rdc1; d0 = dnc0; d1 = dnc1;
        start = 1'b1;
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            if (c == 1) begin
                start = 1'b0;
                chk(busy0 && busy1, "R7", {name, " busy after start"}, busy0 + busy1, 2);
                chk(!ok0 && !ok1, "R6", {name, " crc_ok low while busy"}, ok0 + ok1, 0);
            end
            if (dbl && c == 3) start = 1'b1;
            if (dbl && c == 4) start = 1'b0;
            if (done0 && t0 < 0) begin
                t0 = c;
                chk(ok0 == exp_ok, req, {name, " byte crc_ok"}, ok0, exp_ok);
                chk(!busy0, "R7", {name, " byte busy low at done"}, busy0, 0);
            end
            if (done1 && t1 < 0) begin
                t1 = c;
                chk(ok1 == exp_ok, req, {name, " bit crc_ok"}, ok1, exp_ok);
            end
        end
        chk(t0 == e0, "R9", {name, " byte done cycle"}, t0, e0);
        chk(t1 == e1, "R9", {name, " bit done cycle"}, t1, e1);
        chk(dnc0 - d0 == 1 && dnc1 - d1 == 1, "R6", {name, " single done"},
            (dnc0 - d0) + (dnc1 - d1), 2);
        chk(rdc0 - r0 == nrd, "R8", {name, " byte read count"}, rdc0 - r0, nrd);
        chk(rdc1 - r1 == nrd, "R8", {name, " bit read count"}, rdc1 - r1, nrd);
        chk(ok0 == exp_ok && ok1 == exp_ok, "R6", {name, " verdict held"},
            ok0 + ok1, 2 * exp_ok);
    endtask

    task automatic t_reset();
        chk(!busy0 && !done0 && !ok0 && !rd_en0, "R10", "byte reset state",
            busy0 + done0 + ok0 + rd_en0, 0);
        chk(!busy1 && !done1 && !ok1 && !rd_en1, "R10", "bit reset state",
            busy1 + done1 + ok1 + rd_en1, 0);
    endtask

    task automatic t_valid();
        build(3'd0, 5);  run_check("R3", "valid n5", 5, 1'b1, 1'b0);
        build(3'd0, 12); run_check("R3", "valid n12", 12, 1'b1, 1'b0);
    endtask

    task automatic t_min_max();
        build(3'd0, 3);  run_check("R1", "min n3", 3, 1'b1, 1'b0);
        build(3'd0, 31); run_check("R2", "max n31", 31, 1'b1, 1'b0);
    endtask

    task automatic t_bad_a();
        build(3'd0, 7); pkt[5] ^= 8'h10;
        run_check("R1", "bad first check", 7, 1'b0, 1'b0);
    endtask

    task automatic t_bad_b();
        build(3'd0, 7); pkt[6] ^= 8'h01;
        run_check("R2", "bad second check", 7, 1'b0, 1'b0);
    endtask

    task automatic t_b_span();
        build(3'd0, 8); pkt[7] = ref_crc(5, 8'h8C);
        run_check("R2", "second check excluding first", 8, 1'b0, 1'b0);
    endtask

    task automatic t_bad_payload();
        build(3'd0, 9); pkt[3] ^= 8'h80;
        run_check("R3", "bad payload", 9, 1'b0, 1'b0);
    endtask

    task automatic t_hdr_top();
        build(3'b101, 6); run_check("R4", "header top bits", 6, 1'b1, 1'b0);
    endtask

    task automatic t_short();
        for (int n = 0; n < 3; n++) begin
            build(3'd0, n); run_check("R5", $sformatf("short n%0d", n), n, 1'b0, 1'b0);
        end
    endtask

    task automatic t_double_start();
        build(3'd0, 6); run_check("R7", "start while busy", 6, 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        build(3'd0, 4); run_check("R6", "hold pass", 4, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        chk(ok0 && ok1 && !done0 && !done1, "R6", "crc_ok holds while idle",
            ok0 + ok1, 2);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) pkt[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_valid();
        t_min_max();
        t_bad_a();
        t_bad_b();
        t_b_span();
        t_bad_payload();
        t_hdr_top();
        t_short();
        t_double_start();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule